// File: doc/BRIEF.md
# Windowed Keyed Watchdog Timer

This block is a watchdog counter that runs on a slow dedicated clock and asks the chip's reset controller for a reset whenever software stops servicing it, or services it the wrong way. To service it, software writes a fixed key byte to a service register through a simple register-write port on the bus clock. The write port also carries a flag that marks single-bit accesses, which the watchdog treats as illegal.

The configuration pins are captured while reset is held and then stay frozen until the next reset. They set the enable, the overflow period, the size of the service window and whether the counter keeps running in standby. Only the first service after a reset may land at any count. Every later service must land while the window is open, which is the upper part of the count range. The key write crosses into the watchdog clock through a two-flop synchronizer, so the clear takes effect a few watchdog cycles after the bus write. The watchdog reports a violation as a single-cycle reset request, and then returns all of its internal state to its post-reset values.

Top module: `win_watchdog`

## Requirements
- R1: With the enable captured as 0, `count` stays 0 and `rst_req` stays 0 whatever is written. With it captured as 1, `count` starts at 0 when reset is released and rises by one on every watchdog clock edge.
- R2: With overflow select n (0..7), the overflow value is 2^(BASE_EXP+n). If `count` reaches that value minus 1 and no valid service arrives, `rst_req` rises on the next watchdog edge.
- R3: An accepted write of 0xAC without the bit-access flag clears `count` to 0 within four watchdog cycles, and counting then resumes.
- R4: A write of any byte other than 0xAC produces a reset request.
- R5: A write with `wr_bitop` = 1 produces a reset request, even when the data is 0xAC.
- R6: The first key write after a reset (or after a reset request) is accepted at any count below overflow, including while the window is closed.
- R7: Every later key write must land while the window is open, otherwise a reset request follows. The window is open when `count` ≥ threshold, where the threshold for window select 2'b00, 2'b01, 2'b10 and 2'b11 is 3/4, 1/2, 1/4 and 0 of the overflow value.
- R8: With the standby bit 0, `count` holds its value while `sleep` is 1. On the first watchdog edge with `sleep` back at 0, `count` becomes 0.
- R9: With the standby bit 1, `count` keeps rising by one per watchdog edge while `sleep` is 1.
- R10: `rst_req` is high for exactly one watchdog cycle. On the next cycle `count` is 0 and the next key write counts as a first write again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock for the service register write port |
| wdt_clk | input | 1 | Slow watchdog counting clock |
| rst_n | input | 1 | Active-low synchronous reset for both domains; configuration is captured while low |
| cfg_en | input | 1 | Watchdog enable, captured at reset |
| cfg_ovf_sel | input | 3 | Overflow period select n, period 2^(BASE_EXP+n) |
| cfg_win_sel | input | 2 | Window threshold select |
| cfg_stby_run | input | 1 | 1: keep counting during sleep; 0: hold and clear on wake |
| sleep | input | 1 | Sleep indication, watchdog clock domain |
| wr_en | input | 1 | One bus-cycle strobe for a service register write |
| wr_data | input | 8 | Data byte of the write |
| wr_bitop | input | 1 | The write is a single-bit access |
| rst_req | output | 1 | Single-cycle internal reset request |
| count | output | BASE_EXP+7 | Current watchdog count |

## Verification
The properties assume that the configuration pins stay steady outside reset and that no service write is in flight while `sleep` changes. Without these, a captured value could differ from the pin, or a synchronized event could clear or fire the counter during a hold. The stimulus changes configuration only while `rst_n` is low. It raises and lowers `sleep` only after the monitor window of the last write has closed. All pins are driven on the falling edge of their clock.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_HOLD,
        ST_FIRE
    } wd_state_e;

    localparam logic [7:0] SERVICE_KEY = 8'hAC;

    localparam int EV_GOOD = 0;
    localparam int EV_BAD  = 1;
    localparam int EV_NUM  = 2;

endpackage

// File: rtl/wwdt_key_check.sv
module wwdt_key_check
    import wwdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_bitop,
    output logic [EV_NUM-1:0] ev_tgl
);

    logic key_ok;

    always_comb begin
        key_ok = (wr_data == SERVICE_KEY) && !wr_bitop;
    end

    // each classified write flips one toggle; the slow side sees the change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_tgl <= '0;
        end else if (wr_en) begin
            if (key_ok) begin
                ev_tgl[EV_GOOD] <= ~ev_tgl[EV_GOOD];
            end else begin
                ev_tgl[EV_BAD] <= ~ev_tgl[EV_BAD];
            end
        end
    end

endmodule

// File: rtl/wwdt_evt_sync.sv
module wwdt_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic pulse
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q[0] <= 1'b0;
        end else begin
            chain_q[0] <= tgl_in;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q[s] <= 1'b0;
            end else begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= chain_q[STAGES-1];
        end
    end

    always_comb begin
        pulse = chain_q[STAGES-1] ^ last_q;
    end

endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
    import wwdt_pkg::*;
#(
    parameter int BASE_EXP = 7,
    parameter int CW       = BASE_EXP + 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [2:0]    cfg_ovf_sel,
    input  logic [1:0]    cfg_win_sel,
    input  logic          cfg_stby_run,
    input  logic          sleep,
    input  logic          ev_good,
    input  logic          ev_bad,
    output logic          rst_req,
    output logic [CW-1:0] count
);

    wd_state_e     state_q, state_nx;
    logic [CW-1:0] cnt_q, cnt_nx;
    logic          first_q, first_nx;
    logic          en_q, stby_q;
    logic [2:0]    ovf_q;
    logic [1:0]    win_q;

    logic [CW:0]   span;
    logic [CW:0]   thr;
    logic [CW-1:0] cnt_max;
    logic          win_open;
    int            sh;

    // overflow span and window threshold from captured selects
    always_comb begin
        sh      = BASE_EXP + int'(ovf_q);
        span    = {{CW{1'b0}}, 1'b1} << sh;
        cnt_max = span[CW-1:0] - {{(CW-1){1'b0}}, 1'b1};
        unique case (win_q)
            2'b00:   thr = span - (span >> 2);
            2'b01:   thr = span >> 1;
            2'b10:   thr = span >> 2;
            default: thr = '0;
        endcase
        win_open = ({1'b0, cnt_q} >= thr);
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        first_nx = first_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_nx = '0;
            end
            ST_RUN, ST_HOLD: begin
                if (ev_bad) begin
                    state_nx = ST_FIRE;
                end else if (ev_good) begin
                    if (first_q || win_open) begin
                        cnt_nx   = '0;
                        first_nx = 1'b0;
                    end else begin
                        state_nx = ST_FIRE;
                    end
                end else if (state_q == ST_RUN) begin
                    if (sleep && !stby_q) begin
                        state_nx = ST_HOLD;
                    end else if (cnt_q == cnt_max) begin
                        state_nx = ST_FIRE;
                    end else begin
                        cnt_nx = cnt_q + {{(CW-1){1'b0}}, 1'b1};
                    end
                end else if (!sleep) begin
                    state_nx = ST_RUN;
                    cnt_nx   = '0;
                end
            end
            ST_FIRE: begin
                cnt_nx   = '0;
                first_nx = 1'b1;
                state_nx = en_q ? ST_RUN : ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
        if (state_nx == ST_FIRE) begin
            cnt_nx = '0;
        end
    end

    // state register; configuration captured while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= cfg_en;
            ovf_q   <= cfg_ovf_sel;
            win_q   <= cfg_win_sel;
            stby_q  <= cfg_stby_run;
            state_q <= cfg_en ? ST_RUN : ST_IDLE;
            cnt_q   <= '0;
            first_q <= 1'b1;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
            first_q <= first_nx;
        end
    end

    // outputs
    always_comb begin
        rst_req = (state_q == ST_FIRE);
        count   = cnt_q;
    end

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wwdt_pkg::*;
#(
    parameter int BASE_EXP    = 7,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = BASE_EXP + 7
) (
    input  logic          bus_clk,
    input  logic          wdt_clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [2:0]    cfg_ovf_sel,
    input  logic [1:0]    cfg_win_sel,
    input  logic          cfg_stby_run,
    input  logic          sleep,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          wr_bitop,
    output logic          rst_req,
    output logic [CW-1:0] count
);

    logic [EV_NUM-1:0] ev_tgl;
    logic [EV_NUM-1:0] ev_pulse;

    wwdt_key_check u_key (
        .clk      (bus_clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_bitop (wr_bitop),
        .ev_tgl   (ev_tgl)
    );

    for (genvar g = 0; g < EV_NUM; g++) begin : g_sync
        wwdt_evt_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk    (wdt_clk),
            .rst_n  (rst_n),
            .tgl_in (ev_tgl[g]),
            .pulse  (ev_pulse[g])
        );
    end

    wwdt_core #(
        .BASE_EXP (BASE_EXP),
        .CW       (CW)
    ) u_core (
        .clk          (wdt_clk),
        .rst_n        (rst_n),
        .cfg_en       (cfg_en),
        .cfg_ovf_sel  (cfg_ovf_sel),
        .cfg_win_sel  (cfg_win_sel),
        .cfg_stby_run (cfg_stby_run),
        .sleep        (sleep),
        .ev_good      (ev_pulse[EV_GOOD]),
        .ev_bad       (ev_pulse[EV_BAD]),
        .rst_req      (rst_req),
        .count        (count)
    );

endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk #(
    parameter int BASE_EXP = 7,
    parameter int CW       = BASE_EXP + 7
) (
    input logic          wdt_clk,
    input logic          rst_n,
    input logic          cfg_en,
    input logic [2:0]    cfg_ovf_sel,
    input logic          cfg_stby_run,
    input logic          sleep,
    input logic          rst_req,
    input logic [CW-1:0] count
);

    logic [CW:0] span;
    int          sh;

    always_comb begin
        sh   = BASE_EXP + int'(cfg_ovf_sel);
        span = {{CW{1'b0}}, 1'b1} << sh;
    end

    // R1: disabled watchdog never counts or fires
    p_idle_quiet_r1: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        !cfg_en |-> (count == '0) && !rst_req);

    // R2: count never passes the overflow value minus one
    p_no_overflow_r2: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        cfg_en |-> ({1'b0, count} < span));

    // R10: request is one cycle wide and leaves the count at zero
    p_single_pulse_r10: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        rst_req |=> !rst_req && (count == '0));

    // R8: count frozen during sleep when standby run is off
    p_sleep_hold_r8: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        (cfg_en && !cfg_stby_run && sleep && !rst_req) |=> $stable(count));

    // R8: wake from sleep clears the count
    p_wake_clear_r8: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        (cfg_en && !cfg_stby_run && $fell(sleep) && !$past(rst_req)) |=> (count == '0));

    // R9: count keeps running during sleep when standby run is on
    p_stby_run_r9: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        (cfg_en && cfg_stby_run && sleep && !rst_req && ({1'b0, count} < span - 1'b1))
        |=> (count == $past(count) + {{(CW-1){1'b0}}, 1'b1}) || (count == '0));

endmodule

bind win_watchdog wwdt_chk #(
    .BASE_EXP (BASE_EXP),
    .CW       (CW)
) u_chk (
    .wdt_clk      (wdt_clk),
    .rst_n        (rst_n),
    .cfg_en       (cfg_en),
    .cfg_ovf_sel  (cfg_ovf_sel),
    .cfg_stby_run (cfg_stby_run),
    .sleep        (sleep),
    .rst_req      (rst_req),
    .count        (count)
);

// File: tb/sim_win_watchdog.sv
module sim_win_watchdog;

    localparam int E  = 3;
    localparam int CW = E + 7;

    logic          bus_clk = 1'b0;
    logic          wdt_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b1;
    logic [2:0]    cfg_ovf_sel = 3'd2;
    logic [1:0]    cfg_win_sel = 2'b01;
    logic          cfg_stby_run = 1'b0;
    logic          sleep = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic          wr_bitop = 1'b0;
    logic          rst_req;
    logic [CW-1:0] count;

    always #10 bus_clk = ~bus_clk;   // 50 MHz
    always #40 wdt_clk = ~wdt_clk;

    win_watchdog #(.BASE_EXP(E)) u0 (
        .bus_clk      (bus_clk),
        .wdt_clk      (wdt_clk),
        .rst_n        (rst_n),
        .cfg_en       (cfg_en),
        .cfg_ovf_sel  (cfg_ovf_sel),
        .cfg_win_sel  (cfg_win_sel),
        .cfg_stby_run (cfg_stby_run),
        .sleep        (sleep),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .wr_bitop     (wr_bitop),
        .rst_req      (rst_req),
        .count        (count)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        bit    exp_rst;
        string tag;
    } item_t;

    item_t sb_q[$];
    event  go_ev, done_ev;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic do_reset(input bit en, input logic [2:0] ovf, input logic [1:0] win, input bit stby);
        @(negedge wdt_clk);
        rst_n        = 1'b0;
        sleep        = 1'b0;
        cfg_en       = en;
        cfg_ovf_sel  = ovf;
        cfg_win_sel  = win;
        cfg_stby_run = stby;
        repeat (4) @(negedge wdt_clk);
        rst_n = 1'b1;
    endtask

    task automatic bus_write(input logic [7:0] d, input bit bitop);
        @(negedge bus_clk);
        wr_en    = 1'b1;
        wr_data  = d;
        wr_bitop = bitop;
        @(negedge bus_clk);
        wr_en    = 1'b0;
        wr_bitop = 1'b0;
    endtask

    // driver: push expectation, perform write, hand over to monitor
    task automatic serve(input logic [7:0] d, input bit bitop, input bit exp_rst, input string tag);
        item_t it;
        it.exp_rst = exp_rst;
        it.tag     = tag;
        sb_q.push_back(it);
        bus_write(d, bitop);
        -> go_ev;
        @(done_ev);
    endtask

    // monitor: observe six watchdog cycles, pop and compare
    initial begin
        forever begin
            int    pulses;
            item_t it;
            @(go_ev);
            pulses = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge wdt_clk);
                if (rst_req) pulses++;
            end
            it = sb_q.pop_front();
            check(pulses == (it.exp_rst ? 1 : 0), {it.tag, " reset pulses"}, pulses, it.exp_rst ? 1 : 0);
            check(count <= 6, {it.tag, " count cleared"}, int'(count), 6);
            -> done_ev;
        end
    end

    task automatic wait_overflow(input int exp_prev, input string tag);
        int prev = 0;
        bit seen = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge wdt_clk);
            if (rst_req) begin
                seen = 1'b1;
                break;
            end
            prev = int'(count);
        end
        check(seen && prev == exp_prev, {tag, " count before request"}, prev, exp_prev);
        @(negedge wdt_clk);
        check(!rst_req && count == '0, "R10 one-cycle request then zero", int'(rst_req), 0);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c0;
        // reset state
        rst_n = 1'b0;
        repeat (4) @(negedge wdt_clk);
        check(count == '0, "R1 count in reset", int'(count), 0);
        check(!rst_req, "R1 no request in reset", int'(rst_req), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge wdt_clk);
        check(count == 5, "R1 counts from release", int'(count), 5);

        // overflow 32, threshold 16
        serve(8'hAC, 1'b0, 1'b0, "R6 first write in closed window");
        serve(8'hAC, 1'b0, 1'b1, "R7 second write in closed window");
        serve(8'hAC, 1'b0, 1'b0, "R10 first-write flag restored");
        while (count < 18) @(negedge wdt_clk);
        serve(8'hAC, 1'b0, 1'b0, "R3 R7 key in open window");
        serve(8'h55, 1'b0, 1'b1, "R4 wrong key");
        serve(8'hAC, 1'b1, 1'b1, "R5 bit access with key");
        wait_overflow(31, "R2 overflow sel 2");

        // sleep hold, standby bit 0
        serve(8'hAC, 1'b0, 1'b0, "R3 service before sleep");
        while (count < 8) @(negedge wdt_clk);
        c0 = int'(count);
        sleep = 1'b1;
        repeat (6) @(negedge wdt_clk);
        check(int'(count) == c0, "R8 count held in sleep", int'(count), c0);
        sleep = 1'b0;
        @(negedge wdt_clk);
        check(count == '0, "R8 wake clears count", int'(count), 0);

        // disabled
        do_reset(1'b0, 3'd2, 2'b01, 1'b0);
        repeat (40) @(negedge wdt_clk);
        check(count == '0, "R1 disabled count stays zero", int'(count), 0);
        serve(8'h55, 1'b0, 1'b0, "R1 disabled ignores bad write");

        // always-open window, standby run
        do_reset(1'b1, 3'd2, 2'b11, 1'b1);
        serve(8'hAC, 1'b0, 1'b0, "R6 first write sel 3");
        serve(8'hAC, 1'b0, 1'b0, "R7 window always open");
        c0 = int'(count);
        sleep = 1'b1;
        repeat (4) @(negedge wdt_clk);
        check(int'(count) == c0 + 4, "R9 counts through sleep", int'(count), c0 + 4);
        sleep = 1'b0;

        // shortest period
        do_reset(1'b1, 3'd0, 2'b01, 1'b0);
        wait_overflow(7, "R2 overflow sel 0");

        finish_run();
    end

endmodule